// File: doc/BRIEF.md
# Cascadable Dual 8-bit Timer

This block holds two independent 8-bit up-counters. Each one has a control byte, two compare bytes (A and B), and three sticky event flags: compare A hit, compare B hit and wrap-around. All of these sit on a simple byte-wide register bus. The control byte picks one of three count sources for the counter.

- **Internal tick:** a prescaled tick taken from one free-running divider that both channels share.
- **External pin:** an edge on an external clock pin. The pin is first resynchronised to the system clock.
- **Other channel:** an event coming from the other channel. Channel 0 follows channel 1's wrap-around, and channel 1 follows channel 0's compare-A hit, so the pair can form a 16-bit counter.

The control byte also selects an optional clear of the counter on a compare hit, and it holds one interrupt enable for each flag. Each channel drives three interrupt lines. A line is high while its flag and its enable are both set. Software clears a flag by writing a zero to its bit.

Top module: `dual_tmr8`

## Requirements
- R1: After a synchronous reset, both control bytes read 0x00, both counters read 0x00, all flags read 0, both compare bytes read 0xFF, and every interrupt output is low.
- R2: The register map is as follows. Control is at 0x80 (channel 0) and 0x81 (channel 1). Status is at 0x82/0x83, with bit 7 as the compare-B flag, bit 6 as the compare-A flag, bit 5 as the wrap flag and bits 4:0 reading 0. Compare A is at 0x84/0x85, compare B at 0x86/0x87, and the counter at 0x88/0x89. Any other address reads 0x00.
- R3: Control bits 2:0 select the count source. Code 000 stops the counter. Codes 001, 010 and 011 advance it exactly once in every 8, 64 and 8192 system clocks respectively. These ticks come from a shared divider that restarts at reset.
- R4: Control bits 2:0 also select the pin modes. Code 101 counts falling edges of the pin, 110 counts rising edges and 111 counts both. Each qualifying edge adds exactly one. A pin change first sampled at clock edge k updates the counter at edge k+2.
- R5: Code 100 chains the channels. Channel 0 adds one per channel 1 wrap, and channel 1 adds one per channel 0 compare-A hit. In both cases the count lands one clock after the edge of the event.
- R6: When both channels select code 100 at the same time, neither counter changes.
- R7: A compare hit is a count tick that occurs while the counter equals the compare byte. The matching flag is set at that same clock edge.
- R8: A count tick at 0xFF that is not a clear takes the counter to 0x00 and sets the wrap flag.
- R9: Control bits 4:3 select the clear mode. Code 01 clears on a compare-A hit and code 10 clears on a compare-B hit. In those modes the counter goes to 0x00 and no wrap flag is raised. Codes 00 and 11 never clear the counter.
- R10: Writing a status byte clears each flag whose bit is written as 0 and leaves flags written as 1 unchanged. A hit at the same edge as a clearing write leaves its flag set.
- R11: Control bit 7 enables the compare-B interrupt, bit 6 the compare-A interrupt and bit 5 the wrap interrupt. Each interrupt output is high exactly while its flag and its enable are both 1.
- R12: A bus write to a counter takes effect even when a count tick falls on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one byte per clock |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| ext_clk_in | input | 1 | Asynchronous external count pin |
| irq_cmp_b | output | 2 | Compare-B interrupt, one bit per channel |
| irq_cmp_a | output | 2 | Compare-A interrupt, one bit per channel |
| irq_ovf | output | 2 | Wrap interrupt, one bit per channel |

## Verification
The assertions check several rules on every cycle:
- a stopped counter holds still;
- a tick at a compare value sets the flag, and in a clear mode sends the counter to zero;
- a tick at 0xFF wraps the counter and sets the wrap flag;
- a both-edge pin event steps the counter by exactly one;
- the divider ticks nest;
- both channels freeze when both select the chained source.

Some behaviours appear only in the bench's scenarios, which compare a behavioural model every cycle and add directed checks:
- the exact count rates of the three divided ticks;
- the two-clock pin latency;
- the one-clock delay of the chained count;
- a flag surviving a clearing write on the same edge;
- a counter write beating a same-edge tick;
- the interrupt gating.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    localparam int unsigned DW     = 8;
    localparam int unsigned NUM_CH = 2;

    typedef enum logic [2:0] {
        CK_STOP     = 3'b000,
        CK_DIV_A    = 3'b001,
        CK_DIV_B    = 3'b010,
        CK_DIV_C    = 3'b011,
        CK_CHAIN    = 3'b100,
        CK_PIN_FALL = 3'b101,
        CK_PIN_RISE = 3'b110,
        CK_PIN_BOTH = 3'b111
    } clk_sel_e;

    typedef enum logic [1:0] {
        CLR_NONE = 2'b00,
        CLR_ON_A = 2'b01,
        CLR_ON_B = 2'b10,
        CLR_RSVD = 2'b11
    } clr_mode_e;

    typedef struct packed {
        logic      ie_b;
        logic      ie_a;
        logic      ie_ovf;
        clr_mode_e clr;
        clk_sel_e  cks;
    } tmr_ctl_t;

    typedef struct packed {
        logic cmf_b;
        logic cmf_a;
        logic ovf;
    } tmr_flags_t;

    typedef struct packed {
        logic div_a;
        logic div_b;
        logic div_c;
    } pre_tick_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } pin_ev_t;

    // Register kinds decoded from address bits 7:1; bit 0 picks the channel.
    localparam logic [6:0] KIND_CTL  = 7'h40;
    localparam logic [6:0] KIND_STS  = 7'h41;
    localparam logic [6:0] KIND_CMPA = 7'h42;
    localparam logic [6:0] KIND_CMPB = 7'h43;
    localparam logic [6:0] KIND_CNT  = 7'h44;

    function automatic logic pick_tick(clk_sel_e sel, pre_tick_t pre,
                                       pin_ev_t pin, logic chain);
        logic t;
        case (sel)
            CK_STOP:     t = 1'b0;
            CK_DIV_A:    t = pre.div_a;
            CK_DIV_B:    t = pre.div_b;
            CK_DIV_C:    t = pre.div_c;
            CK_CHAIN:    t = chain;
            CK_PIN_FALL: t = pin.fall;
            CK_PIN_RISE: t = pin.rise;
            CK_PIN_BOTH: t = pin.rise | pin.fall;
            default:     t = 1'b0;
        endcase
        return t;
    endfunction

    function automatic logic [DW-1:0] sts_byte(tmr_flags_t f);
        return {f, {(DW-3){1'b0}}};
    endfunction

endpackage

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler
    import tmr8_pkg::*;
#(
    parameter int unsigned LOG_A = 3,
    parameter int unsigned LOG_B = 6,
    parameter int unsigned LOG_C = 13
) (
    input  logic      clk,
    input  logic      rst,
    output pre_tick_t ticks
);
    localparam int unsigned PW = LOG_C;

    logic [PW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
    end

    always_comb begin
        ticks.div_a = &div_q[LOG_A-1:0];
        ticks.div_b = &div_q[LOG_B-1:0];
        ticks.div_c = &div_q[LOG_C-1:0];
    end

    // R3: a slower tick always coincides with every faster one
    a_r3_nested_ticks: assert property (@(posedge clk) disable iff (rst)
        (ticks.div_c |-> ticks.div_b) and (ticks.div_b |-> ticks.div_a));

endmodule

// File: rtl/tmr8_pin_sync.sv
module tmr8_pin_sync
    import tmr8_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    pin,
    output pin_ev_t ev
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= pin;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[STAGES-2:0], pin};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= sync_q[STAGES-1];
    end

    always_comb begin
        ev.rise = sync_q[STAGES-1] & ~last_q;
        ev.fall = ~sync_q[STAGES-1] & last_q;
    end

endmodule

// File: rtl/tmr8_channel.sv
module tmr8_channel
    import tmr8_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  pre_tick_t     pre,
    input  pin_ev_t       pin,
    input  logic          chain_in,
    input  logic          chain_block,
    input  logic          wr_ctl,
    input  logic          wr_sts,
    input  logic          wr_cmpa,
    input  logic          wr_cmpb,
    input  logic          wr_cnt,
    input  logic [DW-1:0] wdata,
    output tmr_ctl_t      ctl_q,
    output tmr_flags_t    flags_q,
    output logic [DW-1:0] cmpa_q,
    output logic [DW-1:0] cmpb_q,
    output logic [DW-1:0] cnt_q,
    output logic          ev_cmpa_q,
    output logic          ev_ovf_q,
    output logic          irq_b,
    output logic          irq_a,
    output logic          irq_ovf
);
    logic       tick;
    logic       hit_a, hit_b, clr_hit, wrap_hit;
    tmr_flags_t set_v, keep_v;

    always_comb begin
        tick     = pick_tick(ctl_q.cks, pre, pin, chain_in & ~chain_block);
        hit_a    = (cnt_q == cmpa_q);
        hit_b    = (cnt_q == cmpb_q);
        clr_hit  = ((ctl_q.clr == CLR_ON_A) && hit_a) ||
                   ((ctl_q.clr == CLR_ON_B) && hit_b);
        wrap_hit = (&cnt_q) && !clr_hit;
        set_v.cmf_b = tick & hit_b;
        set_v.cmf_a = tick & hit_a;
        set_v.ovf   = tick & wrap_hit;
        keep_v = wr_sts ? tmr_flags_t'(wdata[DW-1:DW-3]) : tmr_flags_t'(3'b111);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q     <= tmr_ctl_t'('0);
            flags_q   <= tmr_flags_t'('0);
            cmpa_q    <= '1;
            cmpb_q    <= '1;
            cnt_q     <= '0;
            ev_cmpa_q <= 1'b0;
            ev_ovf_q  <= 1'b0;
        end else begin
            if (wr_ctl)  ctl_q  <= tmr_ctl_t'(wdata);
            if (wr_cmpa) cmpa_q <= wdata;
            if (wr_cmpb) cmpb_q <= wdata;
            flags_q <= (flags_q & keep_v) | set_v;
            if (wr_cnt)      cnt_q <= wdata;
            else if (tick)   cnt_q <= clr_hit ? '0 : cnt_q + 1'b1;
            ev_cmpa_q <= set_v.cmf_a;
            ev_ovf_q  <= set_v.ovf;
        end
    end

    always_comb begin
        irq_b   = flags_q.cmf_b & ctl_q.ie_b;
        irq_a   = flags_q.cmf_a & ctl_q.ie_a;
        irq_ovf = flags_q.ovf   & ctl_q.ie_ovf;
    end

    // R3: a stopped counter holds its value
    a_r3_stop_holds: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.cks == CK_STOP && !wr_cnt) |=> $stable(cnt_q));

    // R4: one both-edge pin event moves the counter by exactly one
    a_r4_pin_step: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.cks == CK_PIN_BOTH && (pin.rise || pin.fall) && !wr_cnt && !clr_hit)
        |=> cnt_q == DW'($past(cnt_q) + 1'b1));

    // R7: a tick on the compare-A value raises the A flag
    a_r7_match_a_flag: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_q == cmpa_q) |=> flags_q.cmf_a);

    // R8: a tick at the top value wraps and raises the wrap flag
    a_r8_wrap_sets_ovf: assert property (@(posedge clk) disable iff (rst)
        (tick && (&cnt_q) && !clr_hit && !wr_cnt) |=> (cnt_q == '0 && flags_q.ovf));

    // R9: a clearing hit sends the counter to zero
    a_r9_clear_to_zero: assert property (@(posedge clk) disable iff (rst)
        (tick && clr_hit && !wr_cnt) |=> cnt_q == '0);

endmodule

// File: rtl/dual_tmr8.sv
module dual_tmr8
    import tmr8_pkg::*;
#(
    parameter int unsigned PRE_LOG_A   = 3,
    parameter int unsigned PRE_LOG_B   = 6,
    parameter int unsigned PRE_LOG_C   = 13,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] bus_addr,
    input  logic       bus_we,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       ext_clk_in,
    output logic [1:0] irq_cmp_b,
    output logic [1:0] irq_cmp_a,
    output logic [1:0] irq_ovf
);
    pre_tick_t pre;
    pin_ev_t   pin;

    tmr_ctl_t   ctl_v   [NUM_CH];
    tmr_flags_t flags_v [NUM_CH];
    logic [DW-1:0] cmpa_v [NUM_CH];
    logic [DW-1:0] cmpb_v [NUM_CH];
    logic [DW-1:0] cnt_v  [NUM_CH];

    logic [NUM_CH-1:0] ev_cmpa_v, ev_ovf_v, chain_src, wr_cnt_v;
    logic              both_chain;

    tmr8_prescaler #(.LOG_A(PRE_LOG_A), .LOG_B(PRE_LOG_B), .LOG_C(PRE_LOG_C)) u_pre (
        .clk(clk), .rst(rst), .ticks(pre)
    );

    tmr8_pin_sync #(.STAGES(SYNC_STAGES)) u_pin (
        .clk(clk), .rst(rst), .pin(ext_clk_in), .ev(pin)
    );

    assign chain_src[0] = ev_ovf_v[1];
    assign chain_src[1] = ev_cmpa_v[0];
    assign both_chain   = (ctl_v[0].cks == CK_CHAIN) && (ctl_v[1].cks == CK_CHAIN);

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            logic sel;
            assign sel         = bus_we && (bus_addr[0] == 1'(c));
            assign wr_cnt_v[c] = sel && (bus_addr[7:1] == KIND_CNT);

            tmr8_channel u_ch (
                .clk        (clk),
                .rst        (rst),
                .pre        (pre),
                .pin        (pin),
                .chain_in   (chain_src[c]),
                .chain_block(both_chain),
                .wr_ctl     (sel && (bus_addr[7:1] == KIND_CTL)),
                .wr_sts     (sel && (bus_addr[7:1] == KIND_STS)),
                .wr_cmpa    (sel && (bus_addr[7:1] == KIND_CMPA)),
                .wr_cmpb    (sel && (bus_addr[7:1] == KIND_CMPB)),
                .wr_cnt     (wr_cnt_v[c]),
                .wdata      (bus_wdata),
                .ctl_q      (ctl_v[c]),
                .flags_q    (flags_v[c]),
                .cmpa_q     (cmpa_v[c]),
                .cmpb_q     (cmpb_v[c]),
                .cnt_q      (cnt_v[c]),
                .ev_cmpa_q  (ev_cmpa_v[c]),
                .ev_ovf_q   (ev_ovf_v[c]),
                .irq_b      (irq_cmp_b[c]),
                .irq_a      (irq_cmp_a[c]),
                .irq_ovf    (irq_ovf[c])
            );
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        case (bus_addr[7:1])
            KIND_CTL:  bus_rdata = ctl_v[bus_addr[0]];
            KIND_STS:  bus_rdata = sts_byte(flags_v[bus_addr[0]]);
            KIND_CMPA: bus_rdata = cmpa_v[bus_addr[0]];
            KIND_CMPB: bus_rdata = cmpb_v[bus_addr[0]];
            KIND_CNT:  bus_rdata = cnt_v[bus_addr[0]];
            default:   bus_rdata = '0;
        endcase
    end

    // R6: with both channels chained to each other, neither counter moves
    a_r6_both_chain_frozen: assert property (@(posedge clk) disable iff (rst)
        (both_chain && wr_cnt_v == '0) |=> ($stable(cnt_v[0]) && $stable(cnt_v[1])));

endmodule

// File: tb/sim_dual_tmr8.sv
module sim_dual_tmr8;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ext_pin = 1'b0;
    logic [1:0] irq_cmp_b, irq_cmp_a, irq_ovf;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_tmr8 u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk_in(ext_pin),
        .irq_cmp_b(irq_cmp_b), .irq_cmp_a(irq_cmp_a), .irq_ovf(irq_ovf)
    );

    // ---------------- behavioural reference model ----------------
    int m_ctl[2], m_flg[2], m_cmpa[2], m_cmpb[2], m_cnt[2];
    int m_pend_a0, m_pend_o1, m_pc;
    int m_h1, m_h2, m_h3;

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 2; c++) begin
                m_ctl[c] = 0; m_flg[c] = 0; m_cmpa[c] = 255; m_cmpb[c] = 255; m_cnt[c] = 0;
            end
            m_pend_a0 = 0; m_pend_o1 = 0; m_pc = 0; m_h1 = 0; m_h2 = 0; m_h3 = 0;
        end else begin
            int t8, t64, t8k, rise, fall, both;
            int tk, hit_a, hit_b, clr, clr_hit, cks;
            int nc[2], nf[2], sets[2], ea[2], eo[2];
            t8  = (m_pc % 8) == 7;
            t64 = (m_pc % 64) == 63;
            t8k = m_pc == 8191;
            m_pc = (m_pc + 1) % 8192;
            rise = m_h2 && !m_h3;
            fall = !m_h2 && m_h3;
            m_h3 = m_h2; m_h2 = m_h1; m_h1 = int'(ext_pin);
            both = ((m_ctl[0] & 7) == 4) && ((m_ctl[1] & 7) == 4);
            for (int c = 0; c < 2; c++) begin
                cks = m_ctl[c] & 7;
                case (cks)
                    1: tk = t8;
                    2: tk = t64;
                    3: tk = t8k;
                    4: tk = both ? 0 : ((c == 0) ? m_pend_o1 : m_pend_a0);
                    5: tk = fall;
                    6: tk = rise;
                    7: tk = rise || fall;
                    default: tk = 0;
                endcase
                hit_a = m_cnt[c] == m_cmpa[c];
                hit_b = m_cnt[c] == m_cmpb[c];
                clr = (m_ctl[c] >> 3) & 3;
                clr_hit = (clr == 1 && hit_a) || (clr == 2 && hit_b);
                ea[c] = tk && hit_a;
                eo[c] = tk && m_cnt[c] == 255 && !clr_hit;
                sets[c] = ((tk && hit_b) ? 4 : 0) | (ea[c] ? 2 : 0) | (eo[c] ? 1 : 0);
                nc[c] = tk ? (clr_hit ? 0 : (m_cnt[c] + 1) % 256) : m_cnt[c];
                nf[c] = m_flg[c];
            end
            if (bus_we && bus_addr >= 8'h80 && bus_addr <= 8'h89) begin
                int idx;
                idx = int'(bus_addr[0]);
                case (bus_addr[7:1])
                    7'h40: m_ctl[idx]  = int'(bus_wdata);
                    7'h41: nf[idx]     = nf[idx] & int'(bus_wdata[7:5]);
                    7'h42: m_cmpa[idx] = int'(bus_wdata);
                    7'h43: m_cmpb[idx] = int'(bus_wdata);
                    default: nc[idx]   = int'(bus_wdata);
                endcase
            end
            for (int c = 0; c < 2; c++) begin
                m_cnt[c] = nc[c];
                m_flg[c] = nf[c] | sets[c];
            end
            m_pend_a0 = ea[0];
            m_pend_o1 = eo[1];
        end
    end

    function automatic int model_read(logic [7:0] a);
        int i;
        i = int'(a[0]);
        if (a < 8'h80 || a > 8'h89) return 0;
        case (a[7:1])
            7'h40: return m_ctl[i];
            7'h41: return m_flg[i] << 5;
            7'h42: return m_cmpa[i];
            7'h43: return m_cmpb[i];
            default: return m_cnt[i];
        endcase
    endfunction

    // per-cycle comparison, sampled mid-cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            int er;
            er = model_read(bus_addr);
            n_checks++;
            if (int'(bus_rdata) != er) begin
                n_fail++;
                $display("FAIL %s model compare addr %h: actual %h expected %h",
                         cur_req, bus_addr, bus_rdata, er[7:0]);
            end
            for (int c = 0; c < 2; c++) begin
                int eb, ea, eo;
                eb = ((m_flg[c] >> 2) & 1) & ((m_ctl[c] >> 7) & 1);
                ea = ((m_flg[c] >> 1) & 1) & ((m_ctl[c] >> 6) & 1);
                eo = (m_flg[c] & 1) & ((m_ctl[c] >> 5) & 1);
                n_checks++;
                if (int'(irq_cmp_b[c]) != eb || int'(irq_cmp_a[c]) != ea || int'(irq_ovf[c]) != eo) begin
                    n_fail++;
                    $display("FAIL R11 irq ch%0d: actual b%0d a%0d o%0d expected b%0d a%0d o%0d",
                             c, irq_cmp_b[c], irq_cmp_a[c], irq_ovf[c], eb, ea, eo);
                end
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    logic [7:0] scan_list [11] = '{8'h80, 8'h81, 8'h82, 8'h83, 8'h84, 8'h85,
                                   8'h86, 8'h87, 8'h88, 8'h89, 8'h8A};
    int scan_i = 0;

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk); #1;
            bus_addr = scan_list[scan_i];
            scan_i = (scan_i + 1) % 11;
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic chk_rd(logic [7:0] a, logic [7:0] exp, string tag);
        bus_addr = a; #1;
        n_checks++;
        if (bus_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s read %h: actual %h expected %h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic chk_bit(logic act, logic exp, string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic get(logic [7:0] a, output logic [7:0] v);
        bus_addr = a; #1; v = bus_rdata;
    endtask

    task automatic pulse();
        ext_pin = 1'b1; step(4);
        ext_pin = 1'b0; step(4);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset values, R2 map and unmapped reads
        cur_req = "R1";
        chk_rd(8'h80, 8'h00, "R1 ctl0"); chk_rd(8'h81, 8'h00, "R1 ctl1");
        chk_rd(8'h82, 8'h00, "R1 sts0"); chk_rd(8'h83, 8'h00, "R1 sts1");
        chk_rd(8'h84, 8'hFF, "R1 cmpa0"); chk_rd(8'h87, 8'hFF, "R1 cmpb1");
        chk_rd(8'h88, 8'h00, "R1 cnt0"); chk_rd(8'h89, 8'h00, "R1 cnt1");
        chk_bit(|{irq_cmp_b, irq_cmp_a, irq_ovf}, 1'b0, "R1 irqs low");
        cur_req = "R2";
        wr(8'h85, 8'h5A);
        chk_rd(8'h85, 8'h5A, "R2 cmpa1 at 0x85");
        chk_rd(8'h84, 8'hFF, "R2 cmpa0 untouched");
        chk_rd(8'h00, 8'h00, "R2 unmapped 0x00");
        chk_rd(8'h8A, 8'h00, "R2 unmapped 0x8A");
        wr(8'h85, 8'hFF);

        // R3 internal rates
        cur_req = "R3";
        wr(8'h80, 8'h01); step(3);
        get(8'h88, v); step(8); chk_rd(8'h88, v + 8'd1, "R3 div8 window");
        wr(8'h80, 8'h02); step(2);
        get(8'h88, v); step(64); chk_rd(8'h88, v + 8'd1, "R3 div64 window");
        wr(8'h81, 8'h03); step(2);
        get(8'h89, v); step(8192); chk_rd(8'h89, v + 8'd1, "R3 div8192 window");
        wr(8'h80, 8'h00); wr(8'h81, 8'h00); step(2);
        get(8'h88, v); step(100); chk_rd(8'h88, v, "R3 stopped counter holds");

        // R4 external pin modes and latency
        cur_req = "R4";
        wr(8'h81, 8'h06); wr(8'h89, 8'h10);
        ext_pin = 1'b1; step(2);
        chk_rd(8'h89, 8'h10, "R4 no count before latency");
        step(1);
        chk_rd(8'h89, 8'h11, "R4 rising edge counted");
        step(4); ext_pin = 1'b0; step(4);
        chk_rd(8'h89, 8'h11, "R4 falling edge ignored in rising mode");
        wr(8'h81, 8'h05); pulse();
        chk_rd(8'h89, 8'h12, "R4 falling mode one count");
        wr(8'h81, 8'h07); pulse();
        chk_rd(8'h89, 8'h14, "R4 both edges two counts");
        wr(8'h81, 8'h00);

        // R7 / R9 clear on compare A
        cur_req = "R9";
        wr(8'h82, 8'h00); wr(8'h84, 8'h05); wr(8'h80, 8'h0E); wr(8'h88, 8'h00);
        repeat (5) pulse();
        chk_rd(8'h88, 8'h05, "R9 counted up to compare A");
        chk_rd(8'h82, 8'h00, "R7 no flag before hit");
        pulse();
        chk_rd(8'h88, 8'h00, "R9 cleared on compare A");
        chk_rd(8'h82, 8'h40, "R7 compare A flag only");
        cur_req = "R10";
        wr(8'h82, 8'hFF); chk_rd(8'h82, 8'h40, "R10 writing ones keeps flag");
        wr(8'h82, 8'hBF); chk_rd(8'h82, 8'h00, "R10 writing zero clears flag");
        cur_req = "R9";
        wr(8'h86, 8'h03); wr(8'h80, 8'h16); wr(8'h88, 8'h00);
        repeat (4) pulse();
        chk_rd(8'h88, 8'h00, "R9 cleared on compare B");
        chk_rd(8'h82, 8'h80, "R7 compare B flag");
        wr(8'h82, 8'h00); wr(8'h80, 8'h1E); wr(8'h88, 8'h02);
        repeat (4) pulse();
        chk_rd(8'h88, 8'h06, "R9 mode 11 never clears");
        chk_rd(8'h82, 8'hC0, "R7 both compare flags");
        cur_req = "R8";
        wr(8'h82, 8'h00); wr(8'h80, 8'h06); wr(8'h88, 8'hFE);
        repeat (2) pulse();
        chk_rd(8'h88, 8'h00, "R8 wrap to zero");
        chk_rd(8'h82, 8'h20, "R8 wrap flag");
        cur_req = "R9";
        wr(8'h82, 8'h00); wr(8'h84, 8'hFF); wr(8'h80, 8'h0E); wr(8'h88, 8'hFF);
        pulse();
        chk_rd(8'h88, 8'h00, "R9 clear at 0xFF");
        chk_rd(8'h82, 8'h40, "R9 clear raises no wrap flag");

        // R11 interrupt gating
        cur_req = "R11";
        wr(8'h82, 8'h00); wr(8'h84, 8'h10); wr(8'h86, 8'h20);
        wr(8'h80, 8'hE6); wr(8'h88, 8'hFF);
        pulse();
        chk_bit(irq_ovf[0], 1'b1, "R11 wrap irq high");
        chk_bit(irq_cmp_a[0], 1'b0, "R11 compare A irq low");
        chk_bit(irq_cmp_b[0], 1'b0, "R11 compare B irq low");
        wr(8'h88, 8'h10); pulse();
        chk_bit(irq_cmp_a[0], 1'b1, "R11 compare A irq high");
        wr(8'h80, 8'h06);
        chk_bit(irq_ovf[0] | irq_cmp_a[0], 1'b0, "R11 enables off mask irqs");
        chk_rd(8'h82, 8'h60, "R11 flags remain");

        // R10 set wins over same-edge clear
        cur_req = "R10";
        wr(8'h82, 8'h00); wr(8'h84, 8'h07); wr(8'h88, 8'h07);
        pulse();
        chk_rd(8'h82, 8'h40, "R10 setup flag");
        wr(8'h88, 8'h07);
        ext_pin = 1'b1; step(2);
        wr(8'h82, 8'h00);
        step(3); ext_pin = 1'b0; step(4);
        chk_rd(8'h82, 8'h40, "R10 hit beats same-edge clear");
        chk_rd(8'h88, 8'h08, "R10 counter advanced");
        wr(8'h82, 8'h00);

        // R12 counter write beats same-edge tick
        cur_req = "R12";
        ext_pin = 1'b1; step(2);
        wr(8'h88, 8'h40);
        step(3); ext_pin = 1'b0; step(4);
        chk_rd(8'h88, 8'h40, "R12 write wins over tick");

        // R5 cascade both directions
        cur_req = "R5";
        wr(8'h84, 8'h02); wr(8'h80, 8'h0E); wr(8'h88, 8'h00);
        wr(8'h81, 8'h04); wr(8'h89, 8'h00);
        repeat (6) pulse();
        chk_rd(8'h89, 8'h02, "R5 ch1 counts ch0 compare A");
        chk_rd(8'h88, 8'h00, "R5 ch0 cleared");
        wr(8'h80, 8'h04); wr(8'h88, 8'h00); wr(8'h81, 8'h06); wr(8'h89, 8'hFE);
        repeat (2) pulse();
        chk_rd(8'h89, 8'h00, "R5 ch1 wrapped");
        chk_rd(8'h88, 8'h01, "R5 ch0 counts ch1 wrap");

        // R6 both chained: in-flight event is dropped
        cur_req = "R6";
        wr(8'h89, 8'hFF);
        ext_pin = 1'b1; step(2);
        wr(8'h81, 8'h04);
        step(3); ext_pin = 1'b0; step(4);
        chk_rd(8'h89, 8'h00, "R6 ch1 wrapped");
        chk_rd(8'h88, 8'h01, "R6 ch0 frozen");
        step(20);
        chk_rd(8'h88, 8'h01, "R6 ch0 still frozen");

        step(4);
        finish_run();
    end

endmodule